// File: doc/BRIEF.md
# I2C Command Decoder and Byte Engine

This block takes 64-bit command words from a host and turns them into byte-level transactions on one of several I2C ports. The target port comes from a port-select field of the mode setting, presented as an input. A command can open the bus with a start condition and a device address. It then moves a given number of bytes, one at a time, between the data FIFO beside the block and an abstract byte-level bus agent. If the command asks for it, the block closes the transfer with a stop.

The bus agent sits behind a single request/done handshake. It performs bit timing and clock stretching, and it answers each request with an ACK or a NACK. The block keeps two residual counters. The front-end counter counts bytes still to move on the wire. The back-end counter is loaded for the host side and is not decremented here. The block also keeps a snapshot of the FIFO level, sticky invalid-command and NACK bits, a bus-owned flag and one busy bit per port.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, cmd_complete is 1. invalid_cmd, nack_err, bus_owned, bus_req_valid, port_busy and both residual counters are 0.
- R2: A command whose start (bit 63), address-phase (bit 62) and stop (bit 61) flags are all clear, and whose length field (bits LEN_W-1:0) is zero, sets invalid_cmd. It starts no bus request and loads no counter.
- R3: A command that arrives while cmd_complete is 0 is rejected. invalid_cmd is set and both residual counters keep their values.
- R4: An accepted command loads both residual counters with its length in the cycle after cmd_valid. If its start flag is set, cmd_complete drops to 0.
- R5: With start set, the block issues a START request (bus_op 0) carrying the 7-bit device address (bits 55:49), the read flag (bit 60) and the selected port. A NACK sets nack_err, returns cmd_complete to 1 and issues no stop.
- R6: An ACK to START sets bus_owned and the busy bit of the selected port, where port N is bit N of port_busy.
- R7: In read direction (bit 60 set), a RECV request (bus_op 2) is issued only while the FIFO is not full. The received byte is pushed into the FIFO in the cycle bus_done is seen.
- R8: In write direction, a byte is popped from the FIFO head and sent with a SEND request (bus_op 1) only while the FIFO is not empty.
- R9: A NACK to SEND sets nack_err and issues a STOP request (bus_op 3). bus_owned and the port's busy bit clear, and cmd_complete returns to 1.
- R10: Each byte moved lowers the front-end residual by exactly one. One cycle later, stat_fifo_cnt takes the FIFO level. The back-end residual is unchanged.
- R11: When the front-end residual is zero, a command with stop issues STOP, then clears bus_owned and the busy bit before cmd_complete returns to 1. A command without stop sets cmd_complete and keeps the bus owned. cmd_complete is only 1 while no request is pending.
- R12: A non-empty command whose mode port is at or above NUM_PORTS is ignored. No counter is loaded, no flag changes and no request starts.
- R13: At most one bus request is outstanding. bus_req_valid and bus_op hold until bus_done, and each bus_done completes one operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_word | input | 64 | Command word |
| mode_port | input | PORT_SEL_W | Port-select field of the mode setting |
| cmd_complete | output | 1 | No command in progress |
| invalid_cmd | output | 1 | Sticky invalid-command flag |
| nack_err | output | 1 | Sticky NACK-received flag |
| bus_owned | output | 1 | Bus held after an acknowledged start |
| port_busy | output | NUM_PORTS | Per-port busy bits, port N in bit N |
| front_res | output | LEN_W | Front-end residual byte count |
| back_res | output | LEN_W | Back-end residual byte count |
| stat_fifo_cnt | output | CNT_W | FIFO level snapshot taken after each byte |
| fifo_full | input | 1 | FIFO has no room |
| fifo_empty | input | 1 | FIFO holds no data |
| fifo_level | input | CNT_W | FIFO entry count |
| fifo_rdata | input | 8 | FIFO head byte |
| fifo_pop | output | 1 | Remove FIFO head |
| fifo_push | output | 1 | Write fifo_wdata into the FIFO |
| fifo_wdata | output | 8 | Byte to push |
| bus_req_valid | output | 1 | Bus request pending |
| bus_op | output | 2 | 0 START, 1 SEND, 2 RECV, 3 STOP |
| bus_port | output | PORT_SEL_W | Port of the request |
| bus_addr | output | 7 | Device address for START |
| bus_rnw | output | 1 | Direction for START |
| bus_wdata | output | 8 | Byte for SEND |
| bus_done | input | 1 | One-cycle completion of the request |
| bus_nack | input | 1 | NACK result, valid with bus_done |
| bus_rdata | input | 8 | Received byte, valid with bus_done |

## Verification
On every cycle, the assertions check the request handshake and stable opcode, the FIFO room and data guards on push and pop, and the one-step decrement of the front-end counter. They also check that bus ownership only rises after an acknowledged START, that rejected and empty commands set the invalid flag, and that commands to a missing port leave everything untouched. Only the directed scenarios can show the data itself and the counts: received bytes landing in order, sent bytes matching the FIFO order, stalls on a full or empty FIFO resuming when room or data appears, the stop and no-stop endings with the port busy bits, and the two NACK paths.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_SEND  = 2'd1,
      OP_RECV  = 2'd2,
      OP_STOP  = 2'd3
   } bus_op_e;

   localparam int CMD_W      = 64;
   localparam int BIT_START  = 63;
   localparam int BIT_ADDRPH = 62;
   localparam int BIT_STOP   = 61;
   localparam int BIT_RNW    = 60;
   localparam int DEV_LSB    = 49;
   localparam int DEV_W      = 7;
   localparam int LEN_MAX_W  = 16;

   typedef struct packed {
      logic             start;
      logic             addr_ph;
      logic             stop;
      logic             rnw;
      logic [DEV_W-1:0] dev;
   } cmd_flags_t;

endpackage

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
   import i2c_eng_pkg::*;
#(
   parameter int NUM_PORTS  = 3,
   parameter int PORT_SEL_W = 2,
   parameter int LEN_W      = 16
) (
   input  logic [CMD_W-1:0]      cmd_word,
   input  logic [PORT_SEL_W-1:0] port_sel,
   output cmd_flags_t            flags,
   output logic [LEN_W-1:0]      len,
   output logic                  empty_cmd,
   output logic                  port_ok
);
   always_comb begin
      flags.start   = cmd_word[BIT_START];
      flags.addr_ph = cmd_word[BIT_ADDRPH];
      flags.stop    = cmd_word[BIT_STOP];
      flags.rnw     = cmd_word[BIT_RNW];
      flags.dev     = cmd_word[DEV_LSB +: DEV_W];
      len           = cmd_word[LEN_W-1:0];
      empty_cmd     = !flags.start && !flags.addr_ph && !flags.stop && (len == '0);
   end

   generate
      if (NUM_PORTS == (1 << PORT_SEL_W)) begin : g_all_ports
         assign port_ok = 1'b1;
      end else begin : g_range_ports
         assign port_ok = (32'(port_sel) < NUM_PORTS);
      end
   endgenerate
endmodule

// File: rtl/i2c_port_busy.sv
module i2c_port_busy #(
   parameter int NUM_PORTS  = 3,
   parameter int PORT_SEL_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  set_en,
   input  logic                  clr_en,
   input  logic [PORT_SEL_W-1:0] port,
   output logic [NUM_PORTS-1:0]  busy_vec
);
   generate
      for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port
         logic hit;
         assign hit = (port == PORT_SEL_W'(gi));
         always_ff @(posedge clk) begin
            if (!rst_n)             busy_vec[gi] <= 1'b0;
            else if (set_en && hit) busy_vec[gi] <= 1'b1;
            else if (clr_en && hit) busy_vec[gi] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
   import i2c_eng_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int PORT_SEL_W = 2,
   parameter int CNT_W      = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept,
   input  cmd_flags_t            flags,
   input  logic [LEN_W-1:0]      len,
   input  logic [PORT_SEL_W-1:0] port,
   input  logic                  fifo_full,
   input  logic                  fifo_empty,
   input  logic [CNT_W-1:0]      fifo_level,
   input  logic [7:0]            fifo_rdata,
   output logic                  fifo_pop,
   output logic                  fifo_push,
   output logic [7:0]            fifo_wdata,
   output logic                  bus_req_valid,
   output logic [1:0]            bus_op,
   output logic [PORT_SEL_W-1:0] bus_port,
   output logic [DEV_W-1:0]      bus_addr,
   output logic                  bus_rnw,
   output logic [7:0]            bus_wdata,
   input  logic                  bus_done,
   input  logic                  bus_nack,
   input  logic [7:0]            bus_rdata,
   output logic [LEN_W-1:0]      front_res,
   output logic [LEN_W-1:0]      back_res,
   output logic [CNT_W-1:0]      stat_fifo_cnt,
   output logic                  cmd_complete,
   output logic                  nack_err,
   output logic                  bus_owned,
   output logic                  busy_set,
   output logic                  busy_clr
);
   typedef enum logic [2:0] {
      S_IDLE, S_START, S_MOVE, S_XFER, S_STOP
   } state_e;

   state_e                state_q;
   logic [PORT_SEL_W-1:0] port_q;
   logic [DEV_W-1:0]      addr_q;
   logic                  rnw_q;
   logic                  stop_q;
   logic [7:0]            wdata_q;
   logic                  refresh_q;
   logic                  front_zero;
   logic                  can_recv;
   logic                  can_send;
   bus_op_e               op_c;

   assign front_zero = (front_res == '0);
   assign can_recv   = rnw_q && !fifo_full;
   assign can_send   = !rnw_q && !fifo_empty;

   always_comb begin
      unique case (state_q)
         S_XFER:  op_c = rnw_q ? OP_RECV : OP_SEND;
         S_STOP:  op_c = OP_STOP;
         default: op_c = OP_START;
      endcase
   end

   assign bus_op        = op_c;
   assign bus_req_valid = (state_q == S_START) || (state_q == S_XFER) || (state_q == S_STOP);
   assign bus_port      = port_q;
   assign bus_addr      = addr_q;
   assign bus_rnw       = rnw_q;
   assign bus_wdata     = wdata_q;
   assign fifo_pop      = (state_q == S_MOVE) && !front_zero && can_send;
   assign fifo_push     = (state_q == S_XFER) && bus_done && rnw_q;
   assign fifo_wdata    = bus_rdata;
   assign busy_set      = (state_q == S_START) && bus_done && !bus_nack;
   assign busy_clr      = (state_q == S_STOP) && bus_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= S_IDLE;
         port_q        <= '0;
         addr_q        <= '0;
         rnw_q         <= 1'b0;
         stop_q        <= 1'b0;
         wdata_q       <= '0;
         refresh_q     <= 1'b0;
         front_res     <= '0;
         back_res      <= '0;
         stat_fifo_cnt <= '0;
         cmd_complete  <= 1'b1;
         nack_err      <= 1'b0;
         bus_owned     <= 1'b0;
      end else begin
         refresh_q <= 1'b0;
         if (refresh_q) stat_fifo_cnt <= fifo_level;
         unique case (state_q)
            S_IDLE: begin
               if (accept) begin
                  front_res <= len;
                  back_res  <= len;
                  port_q    <= port;
                  addr_q    <= flags.dev;
                  rnw_q     <= flags.rnw;
                  stop_q    <= flags.stop;
                  if (flags.start) begin
                     cmd_complete <= 1'b0;
                     state_q      <= S_START;
                  end
               end
            end
            S_START: begin
               if (bus_done) begin
                  if (bus_nack) begin
                     nack_err     <= 1'b1;
                     cmd_complete <= 1'b1;
                     state_q      <= S_IDLE;
                  end else begin
                     bus_owned <= 1'b1;
                     state_q   <= S_MOVE;
                  end
               end
            end
            S_MOVE: begin
               if (front_zero) begin
                  if (stop_q) begin
                     state_q <= S_STOP;
                  end else begin
                     cmd_complete <= 1'b1;
                     state_q      <= S_IDLE;
                  end
               end else if (can_recv) begin
                  state_q <= S_XFER;
               end else if (can_send) begin
                  wdata_q <= fifo_rdata;
                  state_q <= S_XFER;
               end
            end
            S_XFER: begin
               if (bus_done) begin
                  front_res <= front_res - 1'b1;
                  refresh_q <= 1'b1;
                  if (!rnw_q && bus_nack) begin
                     nack_err <= 1'b1;
                     state_q  <= S_STOP;
                  end else begin
                     state_q <= S_MOVE;
                  end
               end
            end
            S_STOP: begin
               if (bus_done) begin
                  bus_owned    <= 1'b0;
                  cmd_complete <= 1'b1;
                  state_q      <= S_IDLE;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
   import i2c_eng_pkg::*;
#(
   parameter  int NUM_PORTS  = 3,
   parameter  int PORT_SEL_W = 2,
   parameter  int LEN_W      = 16,
   parameter  int FIFO_DEPTH = 8,
   localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic [63:0]           cmd_word,
   input  logic [PORT_SEL_W-1:0] mode_port,
   output logic                  cmd_complete,
   output logic                  invalid_cmd,
   output logic                  nack_err,
   output logic                  bus_owned,
   output logic [NUM_PORTS-1:0]  port_busy,
   output logic [LEN_W-1:0]      front_res,
   output logic [LEN_W-1:0]      back_res,
   output logic [CNT_W-1:0]      stat_fifo_cnt,
   input  logic                  fifo_full,
   input  logic                  fifo_empty,
   input  logic [CNT_W-1:0]      fifo_level,
   input  logic [7:0]            fifo_rdata,
   output logic                  fifo_pop,
   output logic                  fifo_push,
   output logic [7:0]            fifo_wdata,
   output logic                  bus_req_valid,
   output logic [1:0]            bus_op,
   output logic [PORT_SEL_W-1:0] bus_port,
   output logic [6:0]            bus_addr,
   output logic                  bus_rnw,
   output logic [7:0]            bus_wdata,
   input  logic                  bus_done,
   input  logic                  bus_nack,
   input  logic [7:0]            bus_rdata
);
   generate
      if (NUM_PORTS < 1 || NUM_PORTS > (1 << PORT_SEL_W)) begin : g_bad_ports
         $error("NUM_PORTS must lie in 1..2**PORT_SEL_W");
      end
      if (LEN_W < 1 || LEN_W > LEN_MAX_W) begin : g_bad_len
         $error("LEN_W must lie in 1..16");
      end
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 1");
      end
   endgenerate

   cmd_flags_t       flags;
   logic [LEN_W-1:0] len;
   logic             empty_cmd;
   logic             port_ok;
   logic             accept;
   logic             busy_set;
   logic             busy_clr;

   i2c_cmd_decode #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_SEL_W(PORT_SEL_W),
      .LEN_W     (LEN_W)
   ) u_decode (
      .cmd_word (cmd_word),
      .port_sel (mode_port),
      .flags    (flags),
      .len      (len),
      .empty_cmd(empty_cmd),
      .port_ok  (port_ok)
   );

   assign accept = cmd_valid && !empty_cmd && cmd_complete && port_ok;

   always_ff @(posedge clk) begin
      if (!rst_n)
         invalid_cmd <= 1'b0;
      else if (cmd_valid && (empty_cmd || !cmd_complete))
         invalid_cmd <= 1'b1;
   end

   i2c_byte_fsm #(
      .LEN_W     (LEN_W),
      .PORT_SEL_W(PORT_SEL_W),
      .CNT_W     (CNT_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .accept       (accept),
      .flags        (flags),
      .len          (len),
      .port         (mode_port),
      .fifo_full    (fifo_full),
      .fifo_empty   (fifo_empty),
      .fifo_level   (fifo_level),
      .fifo_rdata   (fifo_rdata),
      .fifo_pop     (fifo_pop),
      .fifo_push    (fifo_push),
      .fifo_wdata   (fifo_wdata),
      .bus_req_valid(bus_req_valid),
      .bus_op       (bus_op),
      .bus_port     (bus_port),
      .bus_addr     (bus_addr),
      .bus_rnw      (bus_rnw),
      .bus_wdata    (bus_wdata),
      .bus_done     (bus_done),
      .bus_nack     (bus_nack),
      .bus_rdata    (bus_rdata),
      .front_res    (front_res),
      .back_res     (back_res),
      .stat_fifo_cnt(stat_fifo_cnt),
      .cmd_complete (cmd_complete),
      .nack_err     (nack_err),
      .bus_owned    (bus_owned),
      .busy_set     (busy_set),
      .busy_clr     (busy_clr)
   );

   i2c_port_busy #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_SEL_W(PORT_SEL_W)
   ) u_busy (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (busy_set),
      .clr_en  (busy_clr),
      .port    (bus_port),
      .busy_vec(port_busy)
   );
endmodule

// File: rtl/i2c_cmd_engine_chk.sv
module i2c_cmd_engine_chk #(
   parameter int NUM_PORTS  = 3,
   parameter int PORT_SEL_W = 2,
   parameter int LEN_W      = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cmd_valid,
   input logic [63:0]           cmd_word,
   input logic [PORT_SEL_W-1:0] mode_port,
   input logic                  cmd_complete,
   input logic                  invalid_cmd,
   input logic                  bus_owned,
   input logic [LEN_W-1:0]      front_res,
   input logic                  fifo_full,
   input logic                  fifo_empty,
   input logic                  fifo_pop,
   input logic                  fifo_push,
   input logic                  bus_req_valid,
   input logic [1:0]            bus_op,
   input logic                  bus_done,
   input logic                  bus_nack
);
   // R13
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && !bus_done |=> bus_req_valid && $stable(bus_op));

   // R7
   push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> !fifo_full);

   // R8
   pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty);

   // R10
   front_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> (front_res == $past(front_res)) ||
                     (front_res == $past(front_res) - 1'b1));

   // R6
   own_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_owned) |-> $past(bus_done) && ($past(bus_op) == 2'd0) && !$past(bus_nack));

   // R3
   busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_complete |=> invalid_cmd);

   // R2
   empty_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && (cmd_word[63:61] == 3'b000) && (cmd_word[LEN_W-1:0] == '0) |=> invalid_cmd);

   // R12
   bad_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_complete && (32'(mode_port) >= NUM_PORTS) |=>
         !bus_req_valid && $stable(front_res));

   // R11
   complete_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_complete |-> !bus_req_valid);
endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk #(
   .NUM_PORTS (NUM_PORTS),
   .PORT_SEL_W(PORT_SEL_W),
   .LEN_W     (LEN_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_word     (cmd_word),
   .mode_port    (mode_port),
   .cmd_complete (cmd_complete),
   .invalid_cmd  (invalid_cmd),
   .bus_owned    (bus_owned),
   .front_res    (front_res),
   .fifo_full    (fifo_full),
   .fifo_empty   (fifo_empty),
   .fifo_pop     (fifo_pop),
   .fifo_push    (fifo_push),
   .bus_req_valid(bus_req_valid),
   .bus_op       (bus_op),
   .bus_done     (bus_done),
   .bus_nack     (bus_nack)
);

// File: tb/i2c_cmd_engine_tb.sv
module i2c_cmd_engine_tb;
   localparam int NP    = 3;
   localparam int PW    = 2;
   localparam int LW    = 16;
   localparam int DEPTH = 8;
   localparam int CW    = $clog2(DEPTH + 1);
   localparam int LAT   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [63:0]   cmd_word = '0;
   logic [PW-1:0] mode_port = '0;
   logic          cmd_complete, invalid_cmd, nack_err, bus_owned;
   logic [NP-1:0] port_busy;
   logic [LW-1:0] front_res, back_res;
   logic [CW-1:0] stat_fifo_cnt;
   logic          fifo_full, fifo_empty;
   logic [CW-1:0] fifo_level;
   logic [7:0]    fifo_rdata;
   logic          fifo_pop, fifo_push;
   logic [7:0]    fifo_wdata;
   logic          bus_req_valid;
   logic [1:0]    bus_op;
   logic [PW-1:0] bus_port;
   logic [6:0]    bus_addr;
   logic          bus_rnw;
   logic [7:0]    bus_wdata;
   logic          bus_done = 1'b0;
   logic          bus_nack = 1'b0;
   logic [7:0]    bus_rdata = '0;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   i2c_cmd_engine #(.NUM_PORTS(NP), .PORT_SEL_W(PW), .LEN_W(LW), .FIFO_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .mode_port(mode_port), .cmd_complete(cmd_complete), .invalid_cmd(invalid_cmd),
      .nack_err(nack_err), .bus_owned(bus_owned), .port_busy(port_busy),
      .front_res(front_res), .back_res(back_res), .stat_fifo_cnt(stat_fifo_cnt),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_level(fifo_level),
      .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop), .fifo_push(fifo_push),
      .fifo_wdata(fifo_wdata), .bus_req_valid(bus_req_valid), .bus_op(bus_op),
      .bus_port(bus_port), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
      .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_nack(bus_nack),
      .bus_rdata(bus_rdata)
   );

   // FIFO model beside the block
   logic [7:0] fq [DEPTH];
   int         wp, rp, cnt;
   logic       tb_push = 1'b0, tb_pop = 1'b0;
   logic [7:0] tb_wdata = '0;

   assign fifo_full  = (cnt == DEPTH);
   assign fifo_empty = (cnt == 0);
   assign fifo_level = CW'(cnt);
   assign fifo_rdata = fq[rp];

   always @(posedge clk) begin
      if (!rst_n) begin
         wp <= 0; rp <= 0; cnt <= 0;
         for (int i = 0; i < DEPTH; i++) fq[i] <= '0;
      end else begin
         if (fifo_push || tb_push) begin
            fq[wp] <= fifo_push ? fifo_wdata : tb_wdata;
            wp <= (wp + 1) % DEPTH;
         end
         if (fifo_pop || tb_pop) rp <= (rp + 1) % DEPTH;
         cnt <= cnt + ((fifo_push || tb_push) ? 1 : 0) - ((fifo_pop || tb_pop) ? 1 : 0);
      end
   end

   // Bus agent model
   logic       nack_on_start = 1'b0, nack_on_send = 1'b0;
   int         lat_cnt, n_start, n_send, n_recv, n_stop, proto_err;
   logic [7:0] rd_val;
   logic [7:0] sent [8];
   logic [6:0] last_addr;
   logic       last_rnw;
   logic [PW-1:0] last_port;
   logic [1:0] held_op;

   always @(posedge clk) begin
      if (!rst_n) begin
         bus_done <= 1'b0; bus_nack <= 1'b0; lat_cnt <= 0;
         n_start <= 0; n_send <= 0; n_recv <= 0; n_stop <= 0; proto_err <= 0;
         rd_val <= 8'hA0; last_addr <= '0; last_rnw <= 1'b0; last_port <= '0; held_op <= '0;
         for (int i = 0; i < 8; i++) sent[i] <= '0;
      end else if (bus_req_valid && !bus_done) begin
         if (lat_cnt == 0) held_op <= bus_op;
         else if (bus_op != held_op) proto_err <= proto_err + 1;
         if (lat_cnt == LAT) begin
            lat_cnt  <= 0;
            bus_done <= 1'b1;
            bus_nack <= ((bus_op == 2'd0) && nack_on_start) || ((bus_op == 2'd1) && nack_on_send);
            case (bus_op)
               2'd0: begin n_start <= n_start + 1; last_addr <= bus_addr;
                           last_rnw <= bus_rnw; last_port <= bus_port; end
               2'd1: begin sent[n_send % 8] <= bus_wdata; n_send <= n_send + 1; end
               2'd2: begin bus_rdata <= rd_val; rd_val <= rd_val + 1; n_recv <= n_recv + 1; end
               default: n_stop <= n_stop + 1;
            endcase
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end else begin
         bus_done <= 1'b0;
         bus_nack <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input longint act, input longint exp);
      chk(act == exp, req, act, exp);
   endtask

   function automatic logic [63:0] mk(input bit st, input bit ad, input bit sp, input bit rd,
                                      input logic [6:0] dev, input logic [15:0] len);
      logic [63:0] w = '0;
      w[63] = st; w[62] = ad; w[61] = sp; w[60] = rd;
      w[55:49] = dev; w[15:0] = len;
      return w;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cmd_valid = 1'b0; tb_push = 1'b0; tb_pop = 1'b0;
      nack_on_start = 1'b0; nack_on_send = 1'b0; mode_port = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_cmd(input logic [63:0] w);
      @(negedge clk);
      cmd_word = w; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic push_byte(input logic [7:0] d);
      @(negedge clk);
      tb_push = 1'b1; tb_wdata = d;
      @(negedge clk);
      tb_push = 1'b0;
   endtask

   task automatic pop_byte(output logic [7:0] d);
      @(negedge clk);
      d = fifo_rdata; tb_pop = 1'b1;
      @(negedge clk);
      tb_pop = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (cmd_complete && !bus_req_valid) break;
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk_eq("R1 cmd_complete", cmd_complete, 1);
      chk_eq("R1 invalid_cmd", invalid_cmd, 0);
      chk_eq("R1 nack_err", nack_err, 0);
      chk_eq("R1 bus_owned", bus_owned, 0);
      chk_eq("R1 bus_req_valid", bus_req_valid, 0);
      chk_eq("R1 port_busy", port_busy, 0);
      chk_eq("R1 front_res", front_res, 0);
      chk_eq("R1 back_res", back_res, 0);
   endtask

   task automatic t_empty_cmd();
      do_reset();
      send_cmd(mk(0, 0, 0, 1, 7'h22, 16'd0));
      chk_eq("R2 invalid_cmd", invalid_cmd, 1);
      repeat (6) @(negedge clk);
      chk_eq("R2 no request", n_start + n_send + n_recv + n_stop, 0);
      chk_eq("R2 front_res", front_res, 0);
   endtask

   task automatic t_bad_port();
      do_reset();
      mode_port = 2'd3;
      send_cmd(mk(1, 1, 1, 0, 7'h10, 16'd4));
      repeat (6) @(negedge clk);
      chk_eq("R12 front_res", front_res, 0);
      chk_eq("R12 back_res", back_res, 0);
      chk_eq("R12 invalid_cmd", invalid_cmd, 0);
      chk_eq("R12 no request", n_start, 0);
      chk_eq("R12 cmd_complete", cmd_complete, 1);
   endtask

   task automatic t_read();
      logic [7:0] d;
      do_reset();
      mode_port = 2'd1;
      send_cmd(mk(1, 1, 1, 1, 7'h3C, 16'd3));
      chk_eq("R4 front loaded", front_res, 3);
      chk_eq("R4 back loaded", back_res, 3);
      chk_eq("R4 cmd_complete low", cmd_complete, 0);
      wait_idle();
      chk_eq("R5 start addr", last_addr, 7'h3C);
      chk_eq("R5 start rnw", last_rnw, 1);
      chk_eq("R5 start port", last_port, 1);
      chk_eq("R7 recv count", n_recv, 3);
      chk_eq("R7 fifo level", cnt, 3);
      chk_eq("R10 front_res", front_res, 0);
      chk_eq("R10 back_res", back_res, 3);
      chk_eq("R10 stat_fifo_cnt", stat_fifo_cnt, 3);
      chk_eq("R11 stop issued", n_stop, 1);
      chk_eq("R11 owned cleared", bus_owned, 0);
      chk_eq("R11 port_busy cleared", port_busy, 0);
      chk_eq("R13 protocol", proto_err, 0);
      for (int i = 0; i < 3; i++) begin
         pop_byte(d);
         chk_eq("R7 received byte", d, 8'hA0 + i);
      end
   endtask

   task automatic t_read_full();
      logic [7:0] d;
      do_reset();
      for (int i = 0; i < DEPTH - 1; i++) push_byte(8'h10 + 8'(i));
      send_cmd(mk(1, 1, 1, 1, 7'h21, 16'd3));
      repeat (30) @(negedge clk);
      chk_eq("R7 stall recv count", n_recv, 1);
      chk_eq("R7 stall fifo full", cnt, DEPTH);
      chk_eq("R10 front after one", front_res, 2);
      chk_eq("R7 no request while full", bus_req_valid, 0);
      // R3: second command while the first is stalled
      send_cmd(mk(1, 1, 1, 0, 7'h05, 16'd9));
      chk_eq("R3 invalid_cmd", invalid_cmd, 1);
      chk_eq("R3 front kept", front_res, 2);
      chk_eq("R3 back kept", back_res, 3);
      pop_byte(d);
      pop_byte(d);
      wait_idle();
      chk_eq("R7 resumed recv count", n_recv, 3);
      chk_eq("R10 front done", front_res, 0);
      chk_eq("R13 protocol", proto_err, 0);
   endtask

   task automatic t_write();
      do_reset();
      push_byte(8'h55); push_byte(8'h66); push_byte(8'h77);
      send_cmd(mk(1, 1, 1, 0, 7'h50, 16'd3));
      wait_idle();
      chk_eq("R8 send count", n_send, 3);
      chk_eq("R8 byte 0", sent[0], 8'h55);
      chk_eq("R8 byte 1", sent[1], 8'h66);
      chk_eq("R8 byte 2", sent[2], 8'h77);
      chk_eq("R8 fifo drained", cnt, 0);
      chk_eq("R10 stat_fifo_cnt", stat_fifo_cnt, 0);
      chk_eq("R10 front_res", front_res, 0);
      chk_eq("R13 protocol", proto_err, 0);
   endtask

   task automatic t_write_empty();
      do_reset();
      push_byte(8'h11);
      send_cmd(mk(1, 1, 1, 0, 7'h50, 16'd2));
      repeat (30) @(negedge clk);
      chk_eq("R8 stall send count", n_send, 1);
      chk_eq("R8 stall front", front_res, 1);
      chk_eq("R8 no request while empty", bus_req_valid, 0);
      push_byte(8'h22);
      wait_idle();
      chk_eq("R8 resumed send count", n_send, 2);
      chk_eq("R8 resumed byte", sent[1], 8'h22);
   endtask

   task automatic t_send_nack();
      do_reset();
      push_byte(8'h31); push_byte(8'h32);
      nack_on_send = 1'b1;
      send_cmd(mk(1, 1, 0, 0, 7'h44, 16'd2));
      wait_idle();
      chk_eq("R9 nack_err", nack_err, 1);
      chk_eq("R9 send count", n_send, 1);
      chk_eq("R9 stop issued", n_stop, 1);
      chk_eq("R9 owned cleared", bus_owned, 0);
      chk_eq("R9 port_busy", port_busy, 0);
      chk_eq("R9 cmd_complete", cmd_complete, 1);
      chk_eq("R9 front_res", front_res, 1);
      chk_eq("R9 fifo level", cnt, 1);
   endtask

   task automatic t_start_nack();
      do_reset();
      nack_on_start = 1'b1;
      send_cmd(mk(1, 1, 1, 1, 7'h7E, 16'd2));
      wait_idle();
      chk_eq("R5 nack_err", nack_err, 1);
      chk_eq("R5 no recv", n_recv, 0);
      chk_eq("R5 no stop", n_stop, 0);
      chk_eq("R5 not owned", bus_owned, 0);
      chk_eq("R5 port_busy", port_busy, 0);
      chk_eq("R5 cmd_complete", cmd_complete, 1);
      chk_eq("R5 front kept", front_res, 2);
   endtask

   task automatic t_hold();
      do_reset();
      mode_port = 2'd2;
      push_byte(8'h9A);
      send_cmd(mk(1, 1, 0, 0, 7'h12, 16'd1));
      wait_idle();
      chk_eq("R11 no-stop complete", cmd_complete, 1);
      chk_eq("R6 owned held", bus_owned, 1);
      chk_eq("R6 port 2 busy", port_busy, 3'b100);
      chk_eq("R11 no stop yet", n_stop, 0);
      send_cmd(mk(1, 1, 1, 0, 7'h12, 16'd0));
      wait_idle();
      chk_eq("R11 second start", n_start, 2);
      chk_eq("R11 stop issued", n_stop, 1);
      chk_eq("R11 port released", port_busy, 0);
      chk_eq("R11 owned released", bus_owned, 0);
   endtask

   initial begin
      t_reset();
      t_empty_cmd();
      t_bad_port();
      t_read();
      t_read_full();
      t_write();
      t_write_empty();
      t_send_nack();
      t_start_nack();
      t_hold();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule